// File: doc/BRIEF.md
# Pipelined Converter Correction Back End

This block turns the raw decisions of a ten-bit pipelined analog-to-digital converter into a finished output word. Nine coarse stages each send a two-bit code whose value can be 0, 1 or 2. The extra level is redundancy, so a wrong decision in one stage can be absorbed by the next. A last stage sends one bit. Neighbouring stages run on opposite clock phases, so the codes that belong to one analog sample do not arrive in the same clock. Two stages arrive together, and each following pair arrives one clock later than the pair before it.

The block holds each stage's code back by exactly the right number of clocks, so that a single register captures all the codes of one sample at once. It then adds the codes with overlapping binary weights, which removes the stage errors. The sum passes through two output registers in series. The second register also applies the selected number format. A sample marked valid at the input comes out seven clocks later, and the block can take a new sample every clock.

Top module: `adc_corr_backend`

## Requirements
- R1: The offset-binary result is the sum, over coarse stages k = 1..9, of (code of stage k) × 2^(9−k), plus the final-stage bit. Stage k's code is on `stage_codes[2k-1:2k-2]`. The result range is 0 to 1023.
- R2: A sample whose `in_valid` is high in cycle t appears on `out_word`, with `out_valid` high, in cycle t+7.
- R3: For a sample taken in cycle t, coarse stage k's code is taken from the input in cycle t + floor((k−1)/2). The final bit is taken in cycle t+4.
- R4: If `fmt_twos` is high in cycle t+6, the word in cycle t+7 is two's complement, meaning bit 9 of the offset-binary result is inverted. If `fmt_twos` is low in that cycle, the word is offset binary.
- R5: A stage code of binary 11 adds the same amount as code 10 (value 2).
- R6: `code_err` goes high in the same cycle as the output of a valid sample that carried any code of 11. After that it stays high until reset. A code of 11 in a cycle that belongs to no valid sample leaves `code_err` low.
- R7: While `rst` is high at a rising edge, every delay and output register is cleared. After that edge, `out_valid`, `out_word` and `code_err` are all 0.
- R8: `out_valid` is low in every cycle whose matching input cycle (seven earlier) had `in_valid` low.
- R9: Valid samples on consecutive clocks come out on consecutive clocks, each with its own correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High in the cycle a sample is taken; this is also the cycle its first two stage codes arrive |
| stage_codes | input | 18 | Two-bit codes of the nine coarse stages, stage k in bits [2k-1:2k-2] |
| final_bit | input | 1 | Decision of the last, one-bit stage |
| fmt_twos | input | 1 | Output format: 1 gives two's complement, 0 gives offset binary |
| out_valid | output | 1 | High when out_word holds a sample's result |
| out_word | output | 10 | Corrected ten-bit result |
| code_err | output | 1 | Sticky flag: an illegal stage code was seen in a valid sample |

## Verification
The bench uses the default of nine coarse stages. With that default, the delay lines range from zero to four clocks, the total latency is seven, and the full-scale sum of 1023 can be reached. At this size every lane's delay can be checked by driving each stage's code in its own staggered cycle. The bench can also place overlapping codes (a 1 in one stage and a 2 in the next) that add up to the same word as a single 2, and it can fill the input with all-11 codes in cycles that are not valid.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_BAD  = 2'b11;
    localparam code_t CODE_HIGH = 2'b10;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } fmt_e;

    // Clock offset at which a lane's code arrives (lane 0 is the first stage).
    function automatic int lane_arrival(int lane);
        return lane / 2;
    endfunction

    // Extra delay a lane needs so that it lines up with the last lane.
    function automatic int lane_delay(int lane, int n_stages);
        return lane_arrival(n_stages) - lane_arrival(lane);
    endfunction

    // An illegal code is read as the highest legal value.
    function automatic code_t code_fix(code_t c);
        return (c == CODE_BAD) ? CODE_HIGH : c;
    endfunction

endpackage

// File: rtl/adc_stage_align.sv
module adc_stage_align
    import adc_corr_pkg::*;
#(
    parameter int N_STAGES = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [2*(N_STAGES+1)-1:0]  lanes_in,
    output logic                       aligned_valid,
    output logic [2*(N_STAGES+1)-1:0]  aligned
);
    localparam int LANES = N_STAGES + 1;
    localparam int MAXD  = lane_delay(0, N_STAGES);

    logic [2*LANES-1:0] tap_vec;
    logic               vtap;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int D = lane_delay(g, N_STAGES);
        if (D == 0) begin : g_direct
            assign tap_vec[CODE_W*g +: CODE_W] = lanes_in[CODE_W*g +: CODE_W];
        end else begin : g_delay
            code_t sr [D];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < D; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= lanes_in[CODE_W*g +: CODE_W];
                    for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
                end
            end
            assign tap_vec[CODE_W*g +: CODE_W] = sr[D-1];
        end
    end

    if (MAXD == 0) begin : g_vdirect
        assign vtap = in_valid;
    end else begin : g_vdelay
        logic vsr [MAXD];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MAXD; i++) vsr[i] <= 1'b0;
            end else begin
                vsr[0] <= in_valid;
                for (int i = 1; i < MAXD; i++) vsr[i] <= vsr[i-1];
            end
        end
        assign vtap = vsr[MAXD-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned       <= '0;
            aligned_valid <= 1'b0;
        end else begin
            aligned       <= tap_vec;
            aligned_valid <= vtap;
        end
    end

endmodule

// File: rtl/adc_redundancy_sum.sv
module adc_redundancy_sum
    import adc_corr_pkg::*;
#(
    parameter int N_STAGES = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       aligned_valid,
    input  logic [2*(N_STAGES+1)-1:0]  aligned,
    output logic                       s_valid,
    output logic                       s_illegal,
    output logic [N_STAGES:0]          s_word
);
    localparam int OUT_W = N_STAGES + 1;

    logic [OUT_W-1:0] acc;
    logic             bad;

    always_comb begin
        acc = OUT_W'(aligned[CODE_W*N_STAGES +: CODE_W]);
        bad = 1'b0;
        for (int k = 0; k < N_STAGES; k++) begin
            acc = acc + (OUT_W'(code_fix(aligned[CODE_W*k +: CODE_W])) << (N_STAGES - 1 - k));
            if (aligned[CODE_W*k +: CODE_W] == CODE_BAD) bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid   <= 1'b0;
            s_illegal <= 1'b0;
            s_word    <= '0;
        end else begin
            s_valid   <= aligned_valid;
            s_illegal <= aligned_valid & bad;
            s_word    <= acc;
        end
    end

    // R8: a result is marked valid only if the aligned vector before it was valid
    p_valid_from_align_r8: assert property (@(posedge clk) disable iff (rst)
        s_valid |-> $past(aligned_valid));

endmodule

// File: rtl/adc_out_sync.sv
module adc_out_sync
    import adc_corr_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    input  logic             s_illegal,
    input  logic [OUT_W-1:0] s_word,
    input  logic             fmt_twos,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word,
    output logic             code_err
);
    fmt_e fmt_sel;
    assign fmt_sel = fmt_e'(fmt_twos);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            code_err  <= 1'b0;
        end else begin
            out_valid <= s_valid;
            out_word  <= (fmt_sel == FMT_TWOS) ? {~s_word[OUT_W-1], s_word[OUT_W-2:0]} : s_word;
            code_err  <= code_err | s_illegal;
        end
    end

    // R4: the top bit reflects the format chosen one clock earlier
    p_fmt_msb_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[OUT_W-1] == ($past(s_word[OUT_W-1]) ^ $past(fmt_twos))));

    // R6: the error flag never drops outside reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

    // R6: the flag rises together with a valid output word
    p_err_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err) |-> out_valid);

endmodule

// File: rtl/adc_corr_backend.sv
module adc_corr_backend
    import adc_corr_pkg::*;
#(
    parameter int N_STAGES = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [2*N_STAGES-1:0]   stage_codes,
    input  logic                    final_bit,
    input  logic                    fmt_twos,
    output logic                    out_valid,
    output logic [N_STAGES:0]       out_word,
    output logic                    code_err
);
    localparam int LANES = N_STAGES + 1;
    localparam int OUT_W = N_STAGES + 1;

    logic [CODE_W*LANES-1:0] lanes_in;
    logic [CODE_W*LANES-1:0] aligned;
    logic                    aligned_valid;
    logic                    s_valid;
    logic                    s_illegal;
    logic [OUT_W-1:0]        s_word;

    assign lanes_in = {1'b0, final_bit, stage_codes};

    adc_stage_align #(.N_STAGES(N_STAGES)) i_align (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .lanes_in      (lanes_in),
        .aligned_valid (aligned_valid),
        .aligned       (aligned)
    );

    adc_redundancy_sum #(.N_STAGES(N_STAGES)) i_sum (
        .clk           (clk),
        .rst           (rst),
        .aligned_valid (aligned_valid),
        .aligned       (aligned),
        .s_valid       (s_valid),
        .s_illegal     (s_illegal),
        .s_word        (s_word)
    );

    adc_out_sync #(.OUT_W(OUT_W)) i_out (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s_valid),
        .s_illegal (s_illegal),
        .s_word    (s_word),
        .fmt_twos  (fmt_twos),
        .out_valid (out_valid),
        .out_word  (out_word),
        .code_err  (code_err)
    );

    // R2: every output word follows a valid correction-stage result
    p_valid_chain_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s_valid));

    // R6: the flag only rises after an illegal code in a valid sample
    p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err) |-> $past(s_illegal));

endmodule

// File: tb/test_adc_corr_backend.sv
`timescale 1ns/1ps
module test_adc_corr_backend;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [17:0] stage_codes = '0;
    logic        final_bit = 1'b0;
    logic        fmt_twos = 1'b0;
    logic        out_valid;
    logic [9:0]  out_word;
    logic        code_err;

    always #4 clk = ~clk;

    adc_corr_backend i_adc_corr_backend (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .stage_codes (stage_codes),
        .final_bit   (final_bit),
        .fmt_twos    (fmt_twos),
        .out_valid   (out_valid),
        .out_word    (out_word),
        .code_err    (code_err)
    );

    typedef struct packed {
        logic [17:0] codes;
        logic        fin;
        logic        fmt;
        logic [9:0]  exp;
    } vec_t;

    // Stimulus and expected offset-binary results (R1, R5, R9)
    localparam vec_t VECS [7] = '{
        '{18'h00000, 1'b0, 1'b0, 10'h000},  // all zero
        '{18'h15555, 1'b1, 1'b1, 10'h200},  // every stage 1, final 1
        '{18'h2AAAA, 1'b1, 1'b0, 10'h3FF},  // full scale
        '{18'h00002, 1'b0, 1'b1, 10'h200},  // first stage 2
        '{18'h20000, 1'b1, 1'b0, 10'h003},  // ninth stage 2, final 1
        '{18'h00009, 1'b0, 1'b1, 10'h200},  // overlap: 1 then 2
        '{18'h2AAA8, 1'b1, 1'b0, 10'h1FF}   // first 0, rest 2
    };

    localparam int NS = 40;
    logic [17:0] smp_codes [NS];
    logic        smp_fin   [NS];
    logic        smp_fmt   [NS];
    logic        smp_val   [NS];
    logic        smp_ill   [NS];
    logic [9:0]  smp_exp   [NS];

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic err_exp;
        for (int i = 0; i < NS; i++) begin
            smp_codes[i] = '0; smp_fin[i] = 1'b0; smp_fmt[i] = 1'b0;
            smp_val[i] = 1'b0; smp_ill[i] = 1'b0; smp_exp[i] = '0;
        end
        for (int i = 0; i < 7; i++) begin
            smp_codes[i] = VECS[i].codes; smp_fin[i] = VECS[i].fin;
            smp_fmt[i] = VECS[i].fmt; smp_exp[i] = VECS[i].exp; smp_val[i] = 1'b1;
        end
        // invalid cycles full of illegal codes: must be ignored (R6, R8)
        smp_codes[7] = 18'h3FFFF; smp_fin[7] = 1'b1;
        smp_codes[8] = 18'h3FFFF; smp_fin[8] = 1'b1;
        // third stage illegal 11 counts as 2: 2*64 = 128 (R5, R6)
        smp_codes[9] = 18'h00030; smp_val[9] = 1'b1; smp_ill[9] = 1'b1; smp_exp[9] = 10'h080;
        // zero in two's complement gives 0x200 (R4)
        smp_val[10] = 1'b1; smp_fmt[10] = 1'b1; smp_exp[10] = 10'h000;

        // reset state (R7)
        repeat (3) @(negedge clk);
        chk("R7 out_valid", out_valid, 0);
        chk("R7 out_word", out_word, 0);
        chk("R7 code_err", code_err, 0);
        rst = 1'b0;

        err_exp = 1'b0;
        for (int cyc = 0; cyc < 32; cyc++) begin
            @(negedge clk);
            if (cyc >= 7) begin
                int s;
                logic [9:0] ew;
                s = cyc - 7;
                ew = smp_exp[s];
                if (smp_fmt[s]) ew[9] = ~ew[9];
                chk(smp_val[s] ? "R2 out_valid" : "R8 out_valid", out_valid, smp_val[s]);
                if (smp_val[s]) chk(smp_fmt[s] ? "R4 R1 R3 R9 word" : "R1 R3 R5 R9 word", out_word, ew);
                if (smp_val[s] && smp_ill[s]) err_exp = 1'b1;
                chk("R6 code_err", code_err, err_exp);
            end else begin
                chk("R8 out_valid early", out_valid, 0);
                chk("R6 code_err early", code_err, 0);
            end
            // drive staggered lanes (R3)
            for (int k = 1; k <= 9; k++) begin
                int idx;
                idx = cyc - (k - 1) / 2;
                stage_codes[2*k-2 +: 2] = (idx >= 0 && idx < NS) ? smp_codes[idx][2*k-2 +: 2] : 2'b00;
            end
            final_bit = (cyc >= 4 && cyc - 4 < NS) ? smp_fin[cyc-4] : 1'b0;
            in_valid  = (cyc < NS) ? smp_val[cyc] : 1'b0;
            fmt_twos  = (cyc >= 6 && cyc - 6 < NS) ? smp_fmt[cyc-6] : 1'b0;
        end

        // reset clears the sticky flag (R6, R7)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 out_valid after reset", out_valid, 0);
        chk("R7 out_word after reset", out_word, 0);
        chk("R6 code_err after reset", code_err, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 code_err stays clear", code_err, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule